// File: doc/BRIEF.md
# Accessory Slot Address and Payload Checksum Unit

This unit holds the two checksum engines used when blocks are moved to or from the accessory slot of a game controller. The first engine turns an 11-bit block number into the 16-bit address word sent on the wire. The block number sits in the upper eleven bits. The lower five bits carry a 5-bit CRC of that block number.

The second engine takes a payload one byte per beat. Start and last flags mark the beats. When the payload is complete, the engine returns an 8-bit CRC. The CRC is augmented with eight trailing zero bits. If the accessory-absent input is high, the CRC is inverted. The slot returns this byte after 32 read bytes, and after a write made of a command byte, the 2-byte address and 32 data bytes. The host compares it with the byte this engine computes.

Each engine answers a request with a done pulse and a registered result. The serial transfer and the detection of the accessory type lie outside this unit.

Top module: `acc_crc_top`

## Requirements
- R1: When an address request is accepted, the returned word carries the requested block number in bits 15:5.
- R2: Bits 4:0 of the address word are the remainder of (block number times x^5) modulo x^5+x^4+x^2+1, with the block number taken MSB first and the initial value 0. Examples: block 0x400 gives 0x8001, and block 0 gives 0x0000.
- R3: The address done output is high for exactly the one cycle after each cycle in which the address request valid input is high. The word stays held until the next request.
- R4: The payload CRC is the remainder of (payload bits followed by 8 zero bits) modulo x^8+x^7+x^2+1, with the initial value 0. The first byte goes first, and each byte is taken MSB first. An all-zero payload gives 0x00.
- R5: If the accessory-absent input is high on the beat that carries the last flag, the reported CRC is the bitwise inverse of the R4 value.
- R6: For each accepted last beat, payload done is high for exactly one cycle. That cycle is registered on the clock edge that follows the edge accepting the last beat.
- R7: A beat with the start flag clears the CRC state to 0 before it takes in its byte, whatever earlier partial payload is pending.
- R8: A cycle with beat valid low has no effect on the result. A valid beat that arrives while no payload is open and that has no start flag has no effect either: it produces no done and no change to the result.
- R9: While reset is held, and after it ends, both done outputs are low and both result outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr_req_valid | input | 1 | Address request strobe |
| addr_req_block | input | 11 | Block number to encode |
| addr_rsp_done | output | 1 | Address word ready (one cycle) |
| addr_rsp_word | output | 16 | Block number and 5-bit CRC |
| data_beat_valid | input | 1 | Payload byte present |
| data_beat_start | input | 1 | First byte of a payload |
| data_beat_last | input | 1 | Final byte of a payload |
| data_beat_byte | input | 8 | Payload byte |
| acc_absent | input | 1 | No accessory fitted; inverts the result |
| data_rsp_done | output | 1 | Payload CRC ready (one cycle) |
| data_rsp_crc | output | 8 | Payload CRC |

## Verification
The address engine is given the extreme block numbers 0, 0x001 and 0x7FF, the known value 0x400, and the alternating patterns 0x155 and 0x2AA. Together these separate a wrong polynomial, a reversed bit order and a missing zero augmentation. The payload engine is given payloads that are all zero, all ones and incrementing. The all-zero case exposes a non-zero seed. The other two expose a missing augmentation or a swapped bit order. The same payloads are sent again with the accessory absent, which shows whether inversion happens. Restarts in mid-payload, idle beats without a start flag, and gaps with valid low show whether stale state or stray beats leak into the result.

// File: rtl/acc_crc_pkg.sv
// Shared widths and generator polynomials for the accessory checksum unit.
// Assumes polynomials are given without their leading (implicit) term.
package acc_crc_pkg;
    localparam int BLK_W      = 11;     // block number width
    localparam int ACRC_W     = 5;      // address CRC width
    localparam logic [4:0] ACRC_POLY = 5'h15;
    localparam int DCRC_W     = 8;      // payload CRC width
    localparam logic [7:0] DCRC_POLY = 8'h85;
    localparam int BYTE_W     = 8;      // payload beat width
endpackage

// File: rtl/acc_addr_crc.sv
// Address encoder: packs a block number above its CRC.
// Unrolls every shift step into one combinational chain and registers the word.
// Assumes the result is needed one cycle after the request.
module acc_addr_crc #(
    parameter int          BLK_W  = 11,
    parameter int          CRC_W  = 5,
    parameter logic [CRC_W-1:0] POLY = 5'h15
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic [BLK_W-1:0]       req_block,
    output logic                   rsp_done,
    output logic [BLK_W+CRC_W-1:0] rsp_word
);
    localparam int MSG_W = BLK_W + CRC_W;

    logic [MSG_W-1:0] msg;
    logic [CRC_W-1:0] chain [MSG_W+1];

    // message: block number MSB first followed by CRC_W zero bits
    assign msg      = {req_block, {CRC_W{1'b0}}};
    assign chain[0] = '0;

    for (genvar i = 0; i < MSG_W; i++) begin : g_step
        // one shift of the division register with conditional polynomial xor
        assign chain[i+1] = {chain[i][CRC_W-2:0], msg[MSG_W-1-i]}
                          ^ (chain[i][CRC_W-1] ? POLY : {CRC_W{1'b0}});
    end

    // register the packed word and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done <= 1'b0;
            rsp_word <= '0;
        end else begin
            rsp_done <= req_valid;
            if (req_valid)
                rsp_word <= {req_block, chain[MSG_W]};
        end
    end

    AST_ADDR_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done == $past(req_valid)); // R3
    AST_ADDR_BLOCK_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> rsp_word[MSG_W-1:CRC_W] == $past(req_block)); // R1
    AST_ADDR_ZERO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && $past(req_block) == '0) |-> rsp_word == '0); // R2
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> $stable(rsp_word)); // R3
endmodule

// File: rtl/acc_data_crc.sv
// Payload checksum engine: takes one byte per beat and unrolls 8 bit steps per clock.
// On the last beat it stores the running remainder.
// On the next edge it shifts in the 8 zero bits of augmentation, inverts the result
// if the accessory was absent, and pulses done.
// Assumes start and last qualify only beats with valid high.
module acc_data_crc #(
    parameter int          CRC_W  = 8,
    parameter int          BYTE_W = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h85
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              beat_valid,
    input  logic              beat_start,
    input  logic              beat_last,
    input  logic [BYTE_W-1:0] beat_byte,
    input  logic              absent,
    output logic              rsp_done,
    output logic [CRC_W-1:0]  rsp_crc
);
    logic             active_q;
    logic             pend_q;
    logic             inv_q;
    logic [CRC_W-1:0] crc_q;
    logic             accept;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] mix [BYTE_W+1];
    logic [CRC_W-1:0] aug [CRC_W+1];

    // a beat counts only inside an open payload or when it opens one
    assign accept = beat_valid && (beat_start || active_q);
    // a start flag discards any earlier state
    assign seed   = beat_start ? {CRC_W{1'b0}} : crc_q;

    assign mix[0] = seed;
    for (genvar i = 0; i < BYTE_W; i++) begin : g_mix
        // feed one payload bit, MSB first
        assign mix[i+1] = {mix[i][CRC_W-2:0], beat_byte[BYTE_W-1-i]}
                        ^ (mix[i][CRC_W-1] ? POLY : {CRC_W{1'b0}});
    end

    assign aug[0] = crc_q;
    for (genvar j = 0; j < CRC_W; j++) begin : g_aug
        // feed one zero bit of augmentation
        assign aug[j+1] = {aug[j][CRC_W-2:0], 1'b0}
                        ^ (aug[j][CRC_W-1] ? POLY : {CRC_W{1'b0}});
    end

    // running remainder, payload framing and the finishing pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            inv_q    <= 1'b0;
            crc_q    <= '0;
            rsp_done <= 1'b0;
            rsp_crc  <= '0;
        end else begin
            rsp_done <= pend_q;
            if (pend_q)
                rsp_crc <= aug[CRC_W] ^ {CRC_W{inv_q}};
            if (accept) begin
                crc_q    <= mix[BYTE_W];
                active_q <= !beat_last;
                pend_q   <= beat_last;
                inv_q    <= absent;
            end else begin
                pend_q   <= 1'b0;
            end
        end
    end

    AST_DATA_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done == $past(beat_valid && beat_last && (beat_start || active_q), 2)); // R6
    AST_DATA_STRAY_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_start && !active_q) |=> !pend_q); // R8
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_done |-> $stable(rsp_crc)); // R6
    AST_DATA_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_start && !beat_last) |=> active_q); // R7
endmodule

// File: rtl/acc_crc_top.sv
// Accessory slot checksum unit: an address encoder and a payload CRC engine
// that share clock and reset and are otherwise independent.
module acc_crc_top
    import acc_crc_pkg::*;
#(
    parameter int B_W = BLK_W,
    parameter int A_W = ACRC_W,
    parameter int D_W = DCRC_W,
    parameter int P_W = BYTE_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           addr_req_valid,
    input  logic [B_W-1:0] addr_req_block,
    output logic           addr_rsp_done,
    output logic [B_W+A_W-1:0] addr_rsp_word,
    input  logic           data_beat_valid,
    input  logic           data_beat_start,
    input  logic           data_beat_last,
    input  logic [P_W-1:0] data_beat_byte,
    input  logic           acc_absent,
    output logic           data_rsp_done,
    output logic [D_W-1:0] data_rsp_crc
);
    acc_addr_crc #(.BLK_W(B_W), .CRC_W(A_W), .POLY(A_W'(ACRC_POLY))) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (addr_req_valid),
        .req_block (addr_req_block),
        .rsp_done  (addr_rsp_done),
        .rsp_word  (addr_rsp_word)
    );

    acc_data_crc #(.CRC_W(D_W), .BYTE_W(P_W), .POLY(D_W'(DCRC_POLY))) u_data (
        .clk        (clk),
        .rst_n      (rst_n),
        .beat_valid (data_beat_valid),
        .beat_start (data_beat_start),
        .beat_last  (data_beat_last),
        .beat_byte  (data_beat_byte),
        .absent     (acc_absent),
        .rsp_done   (data_rsp_done),
        .rsp_crc    (data_rsp_crc)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!addr_rsp_done && !data_rsp_done)); // R9
endmodule

// File: tb/acc_crc_top_tb_top.sv
`timescale 1ns/1ps
module acc_crc_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_req_valid = 1'b0;
    logic [10:0] addr_req_block = '0;
    logic        addr_rsp_done;
    logic [15:0] addr_rsp_word;
    logic        data_beat_valid = 1'b0;
    logic        data_beat_start = 1'b0;
    logic        data_beat_last = 1'b0;
    logic [7:0]  data_beat_byte = '0;
    logic        acc_absent = 1'b0;
    logic        data_rsp_done;
    logic [7:0]  data_rsp_crc;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] pay [32];

    always #10 clk = ~clk;

    acc_crc_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .addr_req_valid(addr_req_valid), .addr_req_block(addr_req_block),
        .addr_rsp_done(addr_rsp_done), .addr_rsp_word(addr_rsp_word),
        .data_beat_valid(data_beat_valid), .data_beat_start(data_beat_start),
        .data_beat_last(data_beat_last), .data_beat_byte(data_beat_byte),
        .acc_absent(acc_absent),
        .data_rsp_done(data_rsp_done), .data_rsp_crc(data_rsp_crc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // long division of {block, 5 zeros} by x^5+x^4+x^2+1
    function automatic logic [15:0] ref_addr(input logic [10:0] blk);
        logic [15:0] v = {blk, 5'b0};
        for (int i = 15; i >= 5; i--)
            if (v[i]) v = v ^ (16'h0035 << (i - 5));
        return {blk, v[4:0]};
    endfunction

    // long division of payload bits plus 8 zeros by x^8+x^7+x^2+1
    function automatic logic [7:0] ref_data(input logic inv);
        logic [8:0] r = '0;
        for (int k = 0; k < 33 * 8; k++) begin
            r = {r[7:0], (k < 256) ? pay[k / 8][7 - (k % 8)] : 1'b0};
            if (r[8]) r = r ^ 9'h185;
        end
        return r[7:0] ^ {8{inv}};
    endfunction

    task automatic addr_case(input logic [10:0] blk);
        @(negedge clk);
        addr_req_valid = 1'b1; addr_req_block = blk;
        @(negedge clk);
        addr_req_valid = 1'b0; addr_req_block = ~blk;
        check("R3 addr done", addr_rsp_done, 1);
        check("R1 block field", addr_rsp_word[15:5], blk);
        check("R2 addr crc", addr_rsp_word, ref_addr(blk));
        @(negedge clk);
        check("R3 done one cycle", addr_rsp_done, 0);
        check("R3 word held", addr_rsp_word, ref_addr(blk));
    endtask

    // send pay[] as a payload; gap inserts valid-low cycles with junk bytes
    task automatic send_payload(input logic absent, input bit gap);
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            data_beat_valid = 1'b1;
            data_beat_start = (b == 0);
            data_beat_last  = (b == 31);
            data_beat_byte  = pay[b];
            acc_absent      = (b == 31) ? absent : ~absent;
            if (gap && b % 5 == 2) begin
                @(negedge clk);
                data_beat_valid = 1'b0; data_beat_byte = 8'hA5;
                data_beat_start = 1'b1; data_beat_last = 1'b1;
                @(negedge clk);
                data_beat_valid = 1'b0;
                check("R6 no early done", data_rsp_done, 0);
            end
        end
        @(negedge clk);
        data_beat_valid = 1'b0; data_beat_start = 1'b0; data_beat_last = 1'b0;
        check("R6 not yet done", data_rsp_done, 0);
        @(negedge clk);
        check("R6 done", data_rsp_done, 1);
        check(absent ? "R5 inverted crc" : "R4 payload crc", data_rsp_crc, ref_data(absent));
        @(negedge clk);
        check("R6 single pulse", data_rsp_done, 0);
    endtask

    task automatic test_reset();
        repeat (3) @(negedge clk);
        check("R9 addr done", addr_rsp_done, 0);
        check("R9 data done", data_rsp_done, 0);
        check("R9 addr word", addr_rsp_word, 0);
        check("R9 data crc", data_rsp_crc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 after release", {addr_rsp_done, data_rsp_done}, 0);
    endtask

    task automatic test_addr();
        addr_case(11'h400);
        check("R2 known example", addr_rsp_word, 16'h8001);
        addr_case(11'h000);
        addr_case(11'h001);
        addr_case(11'h7FF);
        addr_case(11'h155);
        addr_case(11'h2AA);
    endtask

    task automatic test_data();
        for (int i = 0; i < 32; i++) pay[i] = 8'h00;
        send_payload(1'b0, 1'b0);
        check("R4 zero payload", data_rsp_crc, 0);
        send_payload(1'b1, 1'b0);
        check("R5 zero payload inverted", data_rsp_crc, 8'hFF);
        for (int i = 0; i < 32; i++) pay[i] = 8'hFF;
        send_payload(1'b0, 1'b0);
        for (int i = 0; i < 32; i++) pay[i] = 8'(i * 7 + 3);
        send_payload(1'b0, 1'b0);
        send_payload(1'b1, 1'b0);
    endtask

    task automatic test_restart();
        // partial payload abandoned, then a full one with start: R7
        for (int b = 0; b < 9; b++) begin
            @(negedge clk);
            data_beat_valid = 1'b1; data_beat_start = (b == 0);
            data_beat_last = 1'b0; data_beat_byte = 8'h3C + 8'(b);
        end
        for (int i = 0; i < 32; i++) pay[i] = 8'(8'hE1 ^ i);
        send_payload(1'b0, 1'b0);
        check("R7 restart clears state", data_rsp_crc, ref_data(1'b0));
    endtask

    task automatic test_ignored();
        // stray beats with no open payload: R8
        for (int b = 0; b < 4; b++) begin
            @(negedge clk);
            data_beat_valid = 1'b1; data_beat_start = 1'b0;
            data_beat_last = 1'b1; data_beat_byte = 8'h5A;
        end
        @(negedge clk);
        data_beat_valid = 1'b0; data_beat_last = 1'b0;
        @(negedge clk);
        check("R8 stray beat no done", data_rsp_done, 0);
        @(negedge clk);
        check("R8 stray beat no done", data_rsp_done, 0);
        check("R8 result untouched", data_rsp_crc, ref_data(1'b0));
        // valid-low gaps with junk inside a payload: R8
        for (int i = 0; i < 32; i++) pay[i] = 8'(i * 29);
        send_payload(1'b0, 1'b1);
        check("R8 gaps ignored", data_rsp_crc, ref_data(1'b0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        test_reset();
        test_addr();
        test_data();
        test_restart();
        test_ignored();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule